// File: doc/BRIEF.md
# Three-Wide Register Rename Stage

This block renames a decoded group of up to three instructions in a single cycle. Each instruction slot carries a valid bit, two logical source registers and one logical destination register. The block keeps a table that maps every logical register to a physical register, and a first-in first-out pool of free physical registers. For every valid slot it returns the physical tags of both sources, a freshly allocated physical destination, and the physical register that the destination was mapped to before, so that a later stage can release it.

Slot 0 is the oldest instruction in the group and slot 2 is the youngest. A source in a younger slot that names a register written by an older valid slot in the same group takes the newest such writer's fresh tag. It does not take the table entry. One logical register can therefore hold several live physical versions in one cycle, and all dependencies are known at the end of the rename cycle. If the pool cannot cover every valid destination, the whole group is held back. A single refill port returns released tags to the pool, one per cycle.

The rename outputs are combinational from the current table and pool state. The table and the pool update at the next rising clock edge when the group is accepted.

Top module: `reg_rename3`

## Requirements
- R1: After reset, logical register i maps to physical register i (for i from 0 to 31), and the pool holds physical tags 32 to 63 in ascending order.
- R2: The sources of slot 0, and any source with no older valid writer in the group, read the mapping that held before the group.
- R3: A source in slot k that names the destination of an older valid slot j < k receives the fresh tag of the youngest such slot j.
- R4: Each valid slot of an accepted group gets a distinct fresh destination. Tags are taken from the head of the pool in slot order, skipping invalid slots.
- R5: After an accepted group, the table holds each written logical register's new tag. When several slots write the same register, the youngest slot's tag wins. The new mapping is visible from the next cycle.
- R6: `out_fire` is 1 only when at least one slot is valid and the pool holds at least as many tags as there are valid slots. A held group allocates nothing and changes no mapping.
- R7: `out_pold` of each valid slot is the destination's previous physical register. This is the fresh tag of the youngest older in-group writer of the same register, or the pre-group mapping if there is none.
- R8: An invalid slot consumes no pool tag, updates no mapping, and never acts as a bypass source for younger slots.
- R9: A tag presented on the refill port is appended at the pool tail in that cycle. Once the tags ahead of it are used, it is handed out to a later destination.
- R10: With no valid slot, `out_fire` is 0 and the state is unchanged, apart from a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 3 | Per-slot valid, bit 0 is the oldest slot |
| in_src_a | input | 3x5 | First logical source per slot |
| in_src_b | input | 3x5 | Second logical source per slot |
| in_dst | input | 3x5 | Logical destination per slot |
| refill_valid | input | 1 | A released tag is presented for return to the pool |
| refill_tag | input | 6 | Physical tag being returned |
| out_fire | output | 1 | Group accepted this cycle |
| out_psrc_a | output | 3x6 | Physical tag of the first source per slot |
| out_psrc_b | output | 3x6 | Physical tag of the second source per slot |
| out_pdst | output | 3x6 | Freshly allocated physical destination per slot |
| out_pold | output | 3x6 | Previous physical mapping of each slot's destination |

## Verification
Several properties are checked on every cycle by the assertions. Fresh destinations inside an accepted group never collide. The pool is never asked for more tags than it holds. A held or empty group leaves the pool level untouched. Slot 1 picks up slot 0's fresh tag whenever it reads slot 0's destination. A refilled tag reaches the pool head when the pool was empty. Other behaviours can only be shown by the bench scenarios, which compare every output against a bench model of the table and the pool. These are youngest-writer-wins in the table, the FIFO order of allocation across invalid slots, the previous-mapping values, and the fact that a held group leaves no trace.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int RN_GROUP    = 3;
    localparam int RN_NUM_LOG  = 32;
    localparam int RN_NUM_PHYS = 64;
    localparam int RN_LTAG_W   = $clog2(RN_NUM_LOG);
    localparam int RN_PTAG_W   = $clog2(RN_NUM_PHYS);

    typedef logic [RN_LTAG_W-1:0] ltag_t;
    typedef logic [RN_PTAG_W-1:0] ptag_t;

    typedef struct packed {
        logic  vld;
        ltag_t src_a;
        ltag_t src_b;
        ltag_t dst;
    } rn_slot_t;

    typedef struct packed {
        ptag_t psrc_a;
        ptag_t psrc_b;
        ptag_t pold;
    } rn_map_rd_t;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
    import rename_pkg::*;
#(
    parameter int GROUP = RN_GROUP,
    localparam int CNT_W = $clog2(GROUP + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           pop_cnt,
    input  logic                       push_vld,
    input  ptag_t                      push_tag,
    output ptag_t [GROUP-1:0]          peek,
    output logic [RN_PTAG_W:0]         level
);
    localparam int DEPTH = RN_NUM_PHYS;
    localparam int INIT  = RN_NUM_PHYS - RN_NUM_LOG;
    localparam logic [RN_PTAG_W:0] DEPTH_C = (RN_PTAG_W + 1)'(DEPTH);
    localparam logic [RN_PTAG_W:0] INIT_C  = (RN_PTAG_W + 1)'(INIT);

    ptag_t              mem [DEPTH];
    ptag_t              head;
    ptag_t              tail;
    logic [RN_PTAG_W:0] cnt;
    logic               push_ok;

    assign push_ok = push_vld && (cnt < DEPTH_C);
    assign level   = cnt;

    generate
        for (genvar k = 0; k < GROUP; k++) begin : g_peek
            assign peek[k] = mem[head + ptag_t'(k)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < INIT) ? ptag_t'(RN_NUM_LOG + i) : '0;
            end
            head <= '0;
            tail <= ptag_t'(INIT);
            cnt  <= INIT_C;
        end else begin
            if (push_ok) begin
                mem[tail] <= push_tag;
                tail      <= tail + ptag_t'(1);
            end
            head <= head + ptag_t'(pop_cnt);
            cnt  <= cnt + (RN_PTAG_W + 1)'(push_ok) - (RN_PTAG_W + 1)'(pop_cnt);
        end
    end

    // R6: the pool never holds more than its depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_C);

    // R6: allocation never exceeds the tags on hand
    p_pop_covered_r6: assert property (@(posedge clk) disable iff (rst)
        (RN_PTAG_W + 1)'(pop_cnt) <= level);

    // R9: a tag refilled into an empty pool is next at the head
    p_refill_head_r9: assert property (@(posedge clk) disable iff (rst)
        (push_vld && level == '0 && pop_cnt == '0) |=> peek[0] == $past(push_tag));
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable
    import rename_pkg::*;
#(
    parameter int GROUP = RN_GROUP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  rn_slot_t [GROUP-1:0]   rd_slot,
    output rn_map_rd_t [GROUP-1:0] rd_data,
    input  logic [GROUP-1:0]       wr_en,
    input  ltag_t [GROUP-1:0]      wr_log,
    input  ptag_t [GROUP-1:0]      wr_phys
);
    ptag_t map [RN_NUM_LOG];

    generate
        for (genvar k = 0; k < GROUP; k++) begin : g_rd
            assign rd_data[k].psrc_a = map[rd_slot[k].src_a];
            assign rd_data[k].psrc_b = map[rd_slot[k].src_b];
            assign rd_data[k].pold   = map[rd_slot[k].dst];
        end
    endgenerate

    // Slots are visited oldest first, so the youngest writer's update lands last.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RN_NUM_LOG; i++) begin
                map[i] <= ptag_t'(i);
            end
        end else begin
            for (int k = 0; k < GROUP; k++) begin
                if (wr_en[k]) begin
                    map[wr_log[k]] <= wr_phys[k];
                end
            end
        end
    end

    // R5: the youngest slot's write is what the table holds afterwards
    p_youngest_wins_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en[GROUP-1] |=> map[$past(wr_log[GROUP-1])] == $past(wr_phys[GROUP-1]));
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass
    import rename_pkg::*;
#(
    parameter int GROUP = RN_GROUP,
    parameter int SLOT  = 0
) (
    input  rn_slot_t [GROUP-1:0] slots,
    input  ptag_t [GROUP-1:0]    fresh,
    input  rn_map_rd_t           tbl,
    output rn_map_rd_t           res
);
    always_comb begin
        res = tbl;
        // Oldest to youngest, so the closest older writer overrides.
        for (int j = 0; j < GROUP; j++) begin
            if (j < SLOT && slots[j].vld) begin
                if (slots[j].dst == slots[SLOT].src_a) res.psrc_a = fresh[j];
                if (slots[j].dst == slots[SLOT].src_b) res.psrc_b = fresh[j];
                if (slots[j].dst == slots[SLOT].dst)   res.pold   = fresh[j];
            end
        end
    end
endmodule

// File: rtl/reg_rename3.sv
module reg_rename3
    import rename_pkg::*;
#(
    parameter int GROUP = RN_GROUP
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [GROUP-1:0]                    in_valid,
    input  logic [GROUP-1:0][RN_LTAG_W-1:0]     in_src_a,
    input  logic [GROUP-1:0][RN_LTAG_W-1:0]     in_src_b,
    input  logic [GROUP-1:0][RN_LTAG_W-1:0]     in_dst,
    input  logic                                refill_valid,
    input  logic [RN_PTAG_W-1:0]                refill_tag,
    output logic                                out_fire,
    output logic [GROUP-1:0][RN_PTAG_W-1:0]     out_psrc_a,
    output logic [GROUP-1:0][RN_PTAG_W-1:0]     out_psrc_b,
    output logic [GROUP-1:0][RN_PTAG_W-1:0]     out_pdst,
    output logic [GROUP-1:0][RN_PTAG_W-1:0]     out_pold
);
    localparam int CNT_W = $clog2(GROUP + 1);

    rn_slot_t [GROUP-1:0]   slots;
    rn_map_rd_t [GROUP-1:0] tbl_rd;
    rn_map_rd_t [GROUP-1:0] final_rd;
    ptag_t [GROUP-1:0]      peek;
    ptag_t [GROUP-1:0]      fresh;
    logic [RN_PTAG_W:0]     level;
    logic [CNT_W-1:0]       need;
    logic [CNT_W-1:0]       ofs [GROUP];
    logic [CNT_W-1:0]       pop_cnt;
    logic [GROUP-1:0]       wr_en;
    ltag_t [GROUP-1:0]      wr_log;

    generate
        for (genvar k = 0; k < GROUP; k++) begin : g_slot
            assign slots[k].vld   = in_valid[k];
            assign slots[k].src_a = in_src_a[k];
            assign slots[k].src_b = in_src_b[k];
            assign slots[k].dst   = in_dst[k];
        end
    endgenerate

    // Pool position of each slot: number of valid slots older than it.
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < GROUP; k++) begin
            ofs[k] = acc;
            acc    = acc + CNT_W'(in_valid[k]);
        end
        need = acc;
    end

    assign out_fire = (need != '0) && ((RN_PTAG_W + 1)'(need) <= level);
    assign pop_cnt  = out_fire ? need : '0;

    generate
        for (genvar k = 0; k < GROUP; k++) begin : g_alloc
            assign fresh[k]      = peek[ofs[k]];
            assign wr_en[k]      = out_fire && in_valid[k];
            assign wr_log[k]     = in_dst[k];
            assign out_pdst[k]   = fresh[k];
            assign out_psrc_a[k] = final_rd[k].psrc_a;
            assign out_psrc_b[k] = final_rd[k].psrc_b;
            assign out_pold[k]   = final_rd[k].pold;

            rn_bypass #(.GROUP(GROUP), .SLOT(k)) i_bypass (
                .slots (slots),
                .fresh (fresh),
                .tbl   (tbl_rd[k]),
                .res   (final_rd[k])
            );
        end
    endgenerate

    rn_freelist #(.GROUP(GROUP)) i_freelist (
        .clk      (clk),
        .rst      (rst),
        .pop_cnt  (pop_cnt),
        .push_vld (refill_valid),
        .push_tag (refill_tag),
        .peek     (peek),
        .level    (level)
    );

    rn_maptable #(.GROUP(GROUP)) i_maptable (
        .clk     (clk),
        .rst     (rst),
        .rd_slot (slots),
        .rd_data (tbl_rd),
        .wr_en   (wr_en),
        .wr_log  (wr_log),
        .wr_phys (fresh)
    );

    // R4: fresh destinations of an accepted group never collide
    generate
        for (genvar i = 0; i < GROUP; i++) begin : g_dist_i
            for (genvar j = i + 1; j < GROUP; j++) begin : g_dist_j
                p_fresh_distinct_r4: assert property (@(posedge clk) disable iff (rst)
                    (out_fire && in_valid[i] && in_valid[j]) |-> out_pdst[i] != out_pdst[j]);
            end
        end
    endgenerate

    // R6, R10: a held or empty group leaves the pool level alone
    p_hold_keeps_level_r6: assert property (@(posedge clk) disable iff (rst)
        (!out_fire && !refill_valid) |=> $stable(level));

    // R3: slot 1 reading slot 0's destination sees slot 0's fresh tag
    p_bypass_slot1_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid[0] && in_valid[1] && in_dst[0] == in_src_a[1]) |-> out_psrc_a[1] == out_pdst[0]);
endmodule

// File: tb/test_reg_rename3.sv
`timescale 1ns/1ps
module test_reg_rename3;
    logic             clk = 1'b0;
    logic             rst;
    logic [2:0]       in_valid;
    logic [2:0][4:0]  in_src_a, in_src_b, in_dst;
    logic             refill_valid;
    logic [5:0]       refill_tag;
    logic             out_fire;
    logic [2:0][5:0]  out_psrc_a, out_psrc_b, out_pdst, out_pold;

    int n_checks = 0;
    int n_fail   = 0;
    int map_m [32];
    int fl_q [$];
    int pend_q [$];
    int cur_sa [3], cur_sb [3], cur_d [3];
    string src_tag  = "R2";
    string dst_tag  = "R4";
    string fire_tag = "R6";

    always #2.5 clk = ~clk;

    reg_rename3 i_reg_rename3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .refill_valid(refill_valid),
        .refill_tag(refill_tag), .out_fire(out_fire), .out_psrc_a(out_psrc_a),
        .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_pold(out_pold)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [2:0] v, input bit rf);
        int need, off, rtag;
        int epd [3], esa [3], esb [3], epo [3];
        bit efire, ba, bb;
        @(negedge clk);
        in_valid = v;
        for (int k = 0; k < 3; k++) begin
            in_src_a[k] = cur_sa[k][4:0];
            in_src_b[k] = cur_sb[k][4:0];
            in_dst[k]   = cur_d[k][4:0];
        end
        refill_valid = 1'b0;
        rtag = 0;
        if (rf && pend_q.size() > 0) begin
            rtag = pend_q.pop_front();
            refill_valid = 1'b1;
            refill_tag = rtag[5:0];
        end
        #1;
        need = 0;
        for (int k = 0; k < 3; k++) need += v[k];
        efire = (need > 0) && (fl_q.size() >= need);
        chk(fire_tag, out_fire, efire);
        if (efire) begin
            off = 0;
            for (int k = 0; k < 3; k++) if (v[k]) begin epd[k] = fl_q[off]; off++; end
            for (int k = 0; k < 3; k++) begin
                if (!v[k]) continue;
                esa[k] = map_m[cur_sa[k]]; esb[k] = map_m[cur_sb[k]]; epo[k] = map_m[cur_d[k]];
                ba = 0; bb = 0;
                for (int j = 0; j < k; j++) begin
                    if (v[j] && cur_d[j] == cur_sa[k]) begin esa[k] = epd[j]; ba = 1; end
                    if (v[j] && cur_d[j] == cur_sb[k]) begin esb[k] = epd[j]; bb = 1; end
                    if (v[j] && cur_d[j] == cur_d[k])  epo[k] = epd[j];
                end
                chk(ba ? "R3" : src_tag, out_psrc_a[k], esa[k]);
                chk(bb ? "R3" : src_tag, out_psrc_b[k], esb[k]);
                chk("R7", out_pold[k], epo[k]);
                chk(dst_tag, out_pdst[k], epd[k]);
            end
            for (int k = 0; k < 3; k++) if (v[k]) begin
                pend_q.push_back(epo[k]);
                map_m[cur_d[k]] = epd[k];
            end
            repeat (need) void'(fl_q.pop_front());
        end
        if (refill_valid) fl_q.push_back(rtag);
    endtask

    task automatic set_slot(input int k, input int sa, input int sb, input int d);
        cur_sa[k] = sa; cur_sb[k] = sb; cur_d[k] = d;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(1234));
        rst = 1'b1; in_valid = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
        refill_valid = 1'b0; refill_tag = '0;
        for (int i = 0; i < 32; i++) map_m[i] = i;
        for (int i = 32; i < 64; i++) fl_q.push_back(i);
        for (int k = 0; k < 3; k++) set_slot(k, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R10: nothing valid, nothing accepted
        fire_tag = "R10";
        step(3'b000, 0);
        fire_tag = "R6";

        // R1: identity mapping and first pool tag 32
        src_tag = "R1";
        set_slot(0, 5, 7, 9);
        step(3'b001, 0);
        src_tag = "R2";

        // R3, R4, R7: three chained writes of register 1
        for (int k = 0; k < 3; k++) set_slot(k, 1, 1, 1);
        step(3'b111, 0);

        // R5: the youngest writer's tag is now in the table
        src_tag = "R5";
        set_slot(0, 1, 9, 2);
        step(3'b001, 0);
        src_tag = "R2";

        // R8: middle slot invalid, writes register 4 that slot 2 reads
        dst_tag = "R8";
        set_slot(0, 3, 3, 6); set_slot(1, 6, 6, 4); set_slot(2, 4, 6, 6);
        step(3'b101, 0);
        dst_tag = "R4";

        // Drain the pool without refills
        while (fl_q.size() >= 3) begin
            for (int k = 0; k < 3; k++)
                set_slot(k, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
            step(3'b111, 0);
        end
        // R6: group larger than the pool is held
        step(3'b111, 0);
        step(3'b111, 0);
        // R6: a group that fits exactly is accepted
        while (fl_q.size() > 0) begin
            step(3'b010, 0);
        end
        step(3'b001, 0);

        // R9: a refilled tag is handed out next
        step(3'b000, 1);
        dst_tag = "R9";
        set_slot(0, 2, 3, 11);
        step(3'b001, 0);
        dst_tag = "R4";

        // Random traffic with refills
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < 3; k++)
                set_slot(k, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
            step(3'($urandom_range(0, 7)), $urandom_range(0, 9) < 6);
        end
        finish_run();
    end
endmodule